// File: doc/BRIEF.md
# Word-Width-Converting Disk Block Buffer

This block sits between a controller that reads and writes single 12-bit disk words by word address and a backing store that moves only whole blocks of 16-bit words. It keeps one resident block of 256 words, together with its block tag, a valid flag and a dirty flag. Front-side accesses that fall in the resident block are served in one cycle. An access to any other block stalls the front side, writes the resident block back if it was modified, and then loads the new block.

Each 12-bit word travels in its own 16-bit store word. Its bits 11:0 carry the data and bits 15:12 are padding. A block number is the word address with the low eight bits dropped, and the backing store uses it directly as the sector index. A modified block that stays idle is written back by itself after a fixed number of quiet cycles, so data does not stay unsaved while no other access comes along.

Top module: `wordblk_buffer`

## Requirements
- R1: After reset the block is idle with `fe_ready` high (no request pending) and no back-side command. The tag is invalid, so the first access to any address, block 0 included, issues a read command for its block.
- R2: A read whose block number (`fe_addr >> 8`) equals the resident tag is accepted with no stall. `fe_rvalid` is high in the cycle after acceptance, and `fe_rdata` holds the last value written to that address, or the stored value if none was written.
- R3: A write to the resident block is accepted with no stall. It updates the word, marks the block dirty and issues no back-side command.
- R4: A miss on a clean or invalid buffer issues exactly one read command, with `bk_cmd_write`=0 and `bk_cmd_lba` = block number. It then takes 256 store words in offset order 0..255, after which the held request is served.
- R5: A miss on a dirty buffer issues a write command (`bk_cmd_write`=1) for the resident tag and sends its 256 words in offset order. Only after that does it issue the read command for the new block.
- R6: Store words carry the 12 data bits in bits 11:0. Bits 15:12 are driven as zero on write-back and are ignored when a block is filled.
- R7: While a fill or write-back is in progress, and while a missing request waits, `fe_ready` is low.
- R8: With the buffer dirty and idle, a write command for the resident block appears exactly `IDLE_TMO` cycles after the last accepted front-side access. Every accepted access restarts this count.
- R9: A clean buffer never starts a timeout write-back, however long it stays idle.
- R10: A completed write-back, whether triggered by a miss or by the timeout, clears the dirty flag. A following miss therefore issues only a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fe_req | input | 1 | Front-side access request, held until accepted |
| fe_we | input | 1 | 1 = write, 0 = read |
| fe_addr | input | ADDR_W | Word address: block number in the high bits, offset in the low 8 |
| fe_wdata | input | DATA_W | Write word |
| fe_ready | output | 1 | Request is accepted at the next edge when `fe_req` and `fe_ready` are both high |
| fe_rvalid | output | 1 | Read data valid, one cycle after a read is accepted |
| fe_rdata | output | DATA_W | Read word |
| bk_cmd_valid | output | 1 | Block command valid |
| bk_cmd_ready | input | 1 | Store accepts the command |
| bk_cmd_write | output | 1 | 1 = write block, 0 = read block |
| bk_cmd_lba | output | ADDR_W-8 | Block / sector index |
| bk_wr_valid | output | 1 | Write-back word valid |
| bk_wr_ready | input | 1 | Store accepts the write-back word |
| bk_wr_data | output | STORE_W | Write-back store word |
| bk_rd_valid | input | 1 | Fill word valid |
| bk_rd_ready | output | 1 | Block accepts a fill word |
| bk_rd_data | input | STORE_W | Fill store word |

## Verification
The hardest case to reach is the idle write-back. It fires only when the buffer is dirty, idle and left untouched for a full timeout window, and every accepted access pushes it out again. The stimulus reaches it in directed phases with a short timeout parameter. It first writes a word and then leaves the front side idle, sampling the command channel on each cycle to confirm that nothing happens before the expected cycle and that the write-back starts exactly on it. A second phase inserts a read partway through the window to show that the count restarts. Random accesses with strong block locality, against a store model that stalls at random, mix hits with clean and dirty misses and check the order of commands on the back side.

// File: rtl/wordblk_pkg.sv
package wordblk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WBACK = 2'd2,
    ST_FLUSH = 2'd3
  } wb_state_t;
endpackage

// File: rtl/wordblk_ram.sv
module wordblk_ram #(
  parameter int AW = 8,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rd_a = mem_q[ra_a];
  assign rd_b = mem_q[ra_b];
endmodule

// File: rtl/wordblk_beat.sv
module wordblk_beat #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == {CW{1'b1}});

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q));
endmodule

// File: rtl/wordblk_idle_timer.sv
module wordblk_idle_timer #(
  parameter int TMO = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expire
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TMO - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == LIMIT);

  // R8
  tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/wordblk_buffer.sv
module wordblk_buffer
  import wordblk_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int OFS_W    = 8,
  parameter int DATA_W   = 12,
  parameter int STORE_W  = 16,
  parameter int IDLE_TMO = 4096
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fe_req,
  input  logic                      fe_we,
  input  logic [ADDR_W-1:0]         fe_addr,
  input  logic [DATA_W-1:0]         fe_wdata,
  output logic                      fe_ready,
  output logic                      fe_rvalid,
  output logic [DATA_W-1:0]         fe_rdata,
  output logic                      bk_cmd_valid,
  input  logic                      bk_cmd_ready,
  output logic                      bk_cmd_write,
  output logic [ADDR_W-OFS_W-1:0]   bk_cmd_lba,
  output logic                      bk_wr_valid,
  input  logic                      bk_wr_ready,
  output logic [STORE_W-1:0]        bk_wr_data,
  input  logic                      bk_rd_valid,
  output logic                      bk_rd_ready,
  input  logic [STORE_W-1:0]        bk_rd_data
);
  localparam int BLK_W = ADDR_W - OFS_W;
  localparam int PAD_W = STORE_W - DATA_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  wb_state_t        state_q, state_d;
  logic             cmd_sent_q, cmd_sent_d;
  logic             valid_q, valid_d;
  logic             dirty_q, dirty_d;
  logic [BLK_W-1:0] tag_q, pend_q, pend_d;
  logic             rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  logic [BLK_W-1:0] fe_blk;
  logic [OFS_W-1:0] fe_ofs, beat;
  logic             hit, in_idle, is_wb, fe_acc;
  logic             wr_fire, rd_fire, blk_done, last_beat, expire;
  logic             mem_we;
  logic [OFS_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata, rd_front, rd_back;
  logic             unused_pad;

  assign fe_blk  = fe_addr[ADDR_W-1:OFS_W];
  assign fe_ofs  = fe_addr[OFS_W-1:0];
  assign hit     = valid_q && (tag_q == fe_blk);
  assign in_idle = (state_q == ST_IDLE);
  assign is_wb   = (state_q == ST_WBACK) || (state_q == ST_FLUSH);

  assign fe_ready = in_idle && (!fe_req || hit);
  assign fe_acc   = fe_req && fe_ready;

  assign bk_cmd_valid = !in_idle && !cmd_sent_q;
  assign bk_cmd_write = is_wb;
  assign bk_cmd_lba   = (state_q == ST_FILL) ? pend_q : tag_q;
  assign bk_wr_valid  = is_wb && cmd_sent_q;
  assign bk_rd_ready  = (state_q == ST_FILL) && cmd_sent_q;
  assign bk_wr_data   = {{PAD_W{1'b0}}, rd_back};
  assign unused_pad   = ^bk_rd_data[STORE_W-1:DATA_W];

  assign wr_fire  = bk_wr_valid && bk_wr_ready;
  assign rd_fire  = bk_rd_valid && bk_rd_ready;
  assign blk_done = (wr_fire || rd_fire) && last_beat;

  assign mem_we    = (fe_acc && fe_we) || rd_fire;
  assign mem_waddr = rd_fire ? beat : fe_ofs;
  assign mem_wdata = rd_fire ? bk_rd_data[DATA_W-1:0] : fe_wdata;

  wordblk_ram #(.AW(OFS_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .ra_a  (fe_ofs),
    .rd_a  (rd_front),
    .ra_b  (beat),
    .rd_b  (rd_back)
  );

  wordblk_beat #(.CW(OFS_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clr   (in_idle),
    .inc   (wr_fire || rd_fire),
    .cnt   (beat),
    .last  (last_beat)
  );

  wordblk_idle_timer #(.TMO(IDLE_TMO)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .clr    (fe_acc || !dirty_q || !in_idle),
    .expire (expire)
  );

  // next state
  always_comb begin
    state_d = state_q;
    valid_d = valid_q;
    dirty_d = dirty_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fe_acc && fe_we) dirty_d = 1'b1;
        if (fe_req && !hit) begin
          pend_d  = fe_blk;
          state_d = (valid_q && dirty_q) ? ST_WBACK : ST_FILL;
        end else if (!fe_req && expire) begin
          state_d = ST_FLUSH;
        end
      end
      ST_WBACK: if (blk_done) begin
        dirty_d = 1'b0;
        state_d = ST_FILL;
      end
      ST_FLUSH: if (blk_done) begin
        dirty_d = 1'b0;
        state_d = ST_IDLE;
      end
      ST_FILL: if (blk_done) begin
        valid_d = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    cmd_sent_d = cmd_sent_q;
    if (state_d != state_q)                cmd_sent_d = 1'b0;
    else if (bk_cmd_valid && bk_cmd_ready) cmd_sent_d = 1'b1;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= ST_IDLE;
      cmd_sent_q <= 1'b0;
      valid_q    <= 1'b0;
      dirty_q    <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmd_sent_q <= cmd_sent_d;
      valid_q    <= valid_d;
      dirty_q    <= dirty_d;
      rvalid_q   <= fe_acc && !fe_we;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (in_idle && fe_req && !hit)        pend_q  <= pend_d;
    if ((state_q == ST_FILL) && blk_done) tag_q   <= pend_q;
    if (fe_acc && !fe_we)                 rdata_q <= rd_front;
  end

  assign fe_rvalid = rvalid_q;
  assign fe_rdata  = rdata_q;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_idle |-> !fe_ready);
  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bk_cmd_valid && !bk_cmd_write) |-> !dirty_q);
  // R3
  wr_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fe_acc && fe_we) |=> dirty_q);
  // R2
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (fe_acc && !fe_we) |=> fe_rvalid);
  // R8
  flush_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (state_q == ST_FLUSH && $past(state_q) == ST_IDLE) |-> $past(dirty_q));
  // R10
  wb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (is_wb && blk_done) |=> !dirty_q);
  // R4
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((state_q == ST_FILL) && blk_done) |=> (valid_q && tag_q == $past(pend_q)));
endmodule

// File: tb/wordblk_buffer_tb.sv
module wordblk_buffer_tb;
  localparam int ADDR_W = 18;
  localparam int BLK_W  = 10;
  localparam int TMO    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fe_req = 1'b0, fe_we = 1'b0;
  logic [ADDR_W-1:0] fe_addr = '0;
  logic [11:0] fe_wdata = '0;
  logic fe_ready, fe_rvalid;
  logic [11:0] fe_rdata;
  logic bk_cmd_valid, bk_cmd_ready, bk_cmd_write;
  logic [BLK_W-1:0] bk_cmd_lba;
  logic bk_wr_valid, bk_wr_ready;
  logic [15:0] bk_wr_data;
  logic bk_rd_valid, bk_rd_ready;
  logic [15:0] bk_rd_data;

  always #5 clk = ~clk;

  wordblk_buffer #(.ADDR_W(ADDR_W), .IDLE_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fe_req(fe_req), .fe_we(fe_we), .fe_addr(fe_addr), .fe_wdata(fe_wdata),
    .fe_ready(fe_ready), .fe_rvalid(fe_rvalid), .fe_rdata(fe_rdata),
    .bk_cmd_valid(bk_cmd_valid), .bk_cmd_ready(bk_cmd_ready),
    .bk_cmd_write(bk_cmd_write), .bk_cmd_lba(bk_cmd_lba),
    .bk_wr_valid(bk_wr_valid), .bk_wr_ready(bk_wr_ready), .bk_wr_data(bk_wr_data),
    .bk_rd_valid(bk_rd_valid), .bk_rd_ready(bk_rd_ready), .bk_rd_data(bk_rd_data)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int a);
    return 12'((a * 2731) ^ 32'h5a3);
  endfunction

  // golden front view and backing store contents
  logic [11:0] gold [int];
  logic [15:0] store [int];
  int log_q [$];
  int exp_q [$];

  function automatic logic [11:0] gval(input int a);
    if (gold.exists(a)) return gold[a];
    return pat(a);
  endfunction

  function automatic logic [15:0] sval(input int a);
    if (store.exists(a)) return store[a];
    return {4'hA, pat(a)};
  endfunction

  // backing store model with random stalls
  logic m_busy = 1'b0, m_wr = 1'b0, m_stall = 1'b0;
  logic [BLK_W-1:0] m_lba = '0;
  int m_cnt = 0;

  assign bk_cmd_ready = !m_busy;
  assign bk_rd_valid  = m_busy && !m_wr && !m_stall;
  assign bk_wr_ready  = m_busy && m_wr && !m_stall;
  assign bk_rd_data   = sval(int'(m_lba) * 256 + m_cnt);

  always @(posedge clk) begin
    m_stall <= ($urandom % 4) == 0;
    if (bk_cmd_valid && bk_cmd_ready) begin
      m_busy <= 1'b1;
      m_wr   <= bk_cmd_write;
      m_lba  <= bk_cmd_lba;
      m_cnt  <= 0;
      log_q.push_back((int'(bk_cmd_write) << 16) | int'(bk_cmd_lba));
    end
    if (bk_rd_valid && bk_rd_ready) begin
      m_cnt <= m_cnt + 1;
      if (m_cnt == 255) m_busy <= 1'b0;
    end
    if (bk_wr_valid && bk_wr_ready) begin
      store[int'(m_lba) * 256 + m_cnt] = bk_wr_data;
      // R6: padding bits written as zero
      chk(bk_wr_data[15:12] == 4'h0, "R6", "write-back pad bits",
          int'(bk_wr_data[15:12]), 0);
      m_cnt <= m_cnt + 1;
      if (m_cnt == 255) m_busy <= 1'b0;
    end
  end

  // expected resident block
  bit exp_valid = 1'b0, exp_dirty = 1'b0;
  int exp_tag = 0;

  task automatic check_log(input string req);
    chk(log_q.size() == exp_q.size(), req, "command count", log_q.size(), exp_q.size());
    if (log_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(log_q[i] == exp_q[i], req, "command {write,lba}", log_q[i], exp_q[i]);
    log_q.delete();
    exp_q.delete();
  endtask

  // one front access; starts and ends just after a falling edge
  task automatic access(input bit we, input int a, input logic [11:0] d);
    int stalls = 0;
    int blk = a >> 8;
    bit hit = exp_valid && (exp_tag == blk);
    fe_req = 1'b1; fe_we = we; fe_addr = ADDR_W'(a); fe_wdata = d;
    #1;
    while (!fe_ready && stalls < 20000) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    fe_req = 1'b0; fe_we = 1'b0;
    if (hit) chk(stalls == 0, we ? "R3" : "R2", "hit stall cycles", stalls, 0);
    else     chk(stalls > 0, "R7", "miss must hold off ready", stalls, 1);
    if (!we) chk(fe_rvalid && fe_rdata == gval(a), "R2", "read data",
                 int'(fe_rdata), int'(gval(a)));
    if (!hit) begin
      if (exp_valid && exp_dirty) exp_q.push_back((1 << 16) | exp_tag);
      exp_q.push_back(blk);
      exp_dirty = 1'b0;
    end
    check_log(!hit ? ((exp_q.size() > 1) ? "R5" : "R4") : "R3");
    exp_valid = 1'b1;
    exp_tag   = blk;
    if (we) begin
      gold[a]   = d;
      exp_dirty = 1'b1;
    end
    #1;
  endtask

  // quiet window after the last accepted access: flush exactly at TMO
  task automatic tmo_window(input string req);
    bit early = 1'b0;
    for (int k = 1; k < TMO; k++) begin
      @(negedge clk);
      if (bk_cmd_valid) early = 1'b1;
    end
    chk(!early, req, "write-back before timeout", int'(early), 0);
    @(negedge clk);
    chk(bk_cmd_valid && bk_cmd_write && int'(bk_cmd_lba) == exp_tag, req,
        "timeout write-back command", int'(bk_cmd_valid), 1);
    repeat (900) @(negedge clk);
    exp_q.push_back((1 << 16) | exp_tag);
    exp_dirty = 1'b0;
    check_log(req);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    chk(fe_ready == 1'b1, "R1", "ready after reset", int'(fe_ready), 1);
    chk(bk_cmd_valid == 1'b0, "R1", "no command after reset", int'(bk_cmd_valid), 0);
    #1;
    // R1: first access to block 0 must still fill (tag invalid), R6 pad ignored
    access(1'b0, 32'h00A, 12'h0);
    // R4 clean miss to block 3, then R2 hits
    access(1'b0, 32'h305, 12'h0);
    access(1'b0, 32'h3FF, 12'h0);
    access(1'b0, 32'h300, 12'h0);
    // R3 hit writes then read back
    access(1'b1, 32'h310, 12'hABC);
    access(1'b1, 32'h3FF, 12'hFFF);
    access(1'b0, 32'h310, 12'h0);
    access(1'b0, 32'h3FF, 12'h0);
    // R5 dirty miss: write-back block 3 then fill block 7
    access(1'b0, 32'h712, 12'h0);
    chk(store.exists(32'h310) && store[32'h310] == 16'h0ABC, "R5",
        "written-back word", int'(sval(32'h310)), 16'h0ABC);
    // R10: block 3 re-read returns written data, only a read command
    access(1'b0, 32'h310, 12'h0);

    // random phase with block locality
    for (int n = 0; n < 300; n++) begin
      int blk = exp_tag;
      int a;
      bit we = ($urandom % 2) == 1;
      if (($urandom % 12) == 0) blk = $urandom % 6;
      a = blk * 256 + ($urandom % 256);
      access(we, a, 12'($urandom));
      repeat ($urandom % 3) @(negedge clk);
      #1;
    end
    repeat (2) @(negedge clk);
    #1;
    // settle: if dirty, let the timeout write-back happen first
    if (exp_dirty) begin
      access(1'b0, exp_tag * 256, 12'h0);
      tmo_window("R8");
      #1;
    end

    // R8 exact timeout after a write
    access(1'b1, exp_tag * 256 + 5, 12'h123);
    tmo_window("R8");
    #1;
    // R8 restart on access
    access(1'b1, exp_tag * 256 + 6, 12'h456);
    begin
      bit any = 1'b0;
      repeat (20) begin
        @(negedge clk);
        if (bk_cmd_valid) any = 1'b1;
      end
      chk(!any, "R8", "no flush inside window", int'(any), 0);
    end
    #1;
    access(1'b0, exp_tag * 256 + 6, 12'h0);
    tmo_window("R8");

    // R9 clean buffer never flushes
    begin
      bit any = 1'b0;
      repeat (3 * TMO) begin
        @(negedge clk);
        if (bk_cmd_valid) any = 1'b1;
      end
      chk(!any, "R9", "command while clean", int'(any), 0);
      check_log("R9");
    end
    #1;
    // R10 miss after flush issues only a read
    access(1'b1, ((exp_tag + 1) % 6) * 256 + 9, 12'h777);
    tmo_window("R10");

    // store must now match every written word (R5, R10)
    begin
      bit ok = 1'b1;
      int bad = 0;
      foreach (gold[k]) if (sval(k) != {4'h0, gold[k]}) begin ok = 1'b0; bad = k; end
      chk(ok, "R10", "store contents after flushes", int'(sval(bad)), int'(gval(bad)));
    end

    summary();
    $finish;
  end
endmodule